// File: doc/BRIEF.md
# Chainable Event Counter Bank

A bank of programmable 32-bit event counters plus one free-running cycle counter, all reached through a flat register interface with a single-cycle write port and a combinational read port. Each event counter has a 10-bit type register that picks how it counts. Event pulses arrive from outside the block, one wire per counter. Two type codes have special meaning. Code 0x000 makes a counter advance only on software-increment writes. Code 0x01E, written into an odd counter, joins it with the even counter below it to form one 64-bit count.

Counting is gated by a global enable bit in the control register and a per-counter enable bit. The enable bits and the overflow flags are each written through a pair of set and clear addresses. A control write can also clear all event counters or the cycle counter. The cycle counter is index 31. It always holds 64 bits, and a long-mode control bit selects whether its overflow flag is raised at the 32-bit or the 64-bit wrap.

Address map, in 7-bit addresses: counter i is at 0x00+i and the cycle counter is at 0x1F. The type of counter i is at 0x20+i. Control is at 0x40. Enable set is 0x41 and enable clear is 0x42. Overflow set is 0x43 and overflow clear is 0x44. Software increment is 0x45. The control fields are global enable at bit 0, clear-event-counters at bit 1, clear-cycle-counter at bit 2, and long cycle mode at bit 6. Bit i of the enable and overflow registers belongs to counter i, and bit 31 belongs to the cycle counter. Unmapped addresses read as zero.

Top module: `evtCounterBank`

## Requirements
- R1: After reset, every counter, type register, the control register, the enable register and the overflow register read as zero.
- R2: An event counter adds one on each clock with its event pulse high, only when global enable (control bit 0) and its enable bit are both 1. Pulses are ignored for a counter whose type is 0x000.
- R3: When an unchained event counter steps from 0xFFFFFFFF to 0, it sets its overflow bit.
- R4: When counter 2k+1 has type 0x01E, the pair forms one 64-bit count: index 2k reads the low half and index 2k+1 reads the high half. The even counter's pulse, type and enable drive the pair, and pulses on the odd counter are ignored. Only overflow bit 2k+1 is set, and only when the full 64-bit value wraps.
- R5: A write to 0x45 adds one to each event counter i whose data bit i is 1, whose type is 0x000 and whose enable bit is 1, whether or not global enable is set. A wrap to zero sets overflow bit i. Bit 31 never touches the cycle counter.
- R6: The cycle counter (address 0x1F, full 64-bit read) adds one every clock while global enable and enable bit 31 are both 1. Overflow bit 31 is set when the low 32 bits wrap if control bit 6 is 0, and when all 64 bits wrap if it is 1.
- R7: A control write with bit 1 set clears all event counters, and one with bit 2 set clears the cycle counter. Neither bit is stored: control reads back only bits 0 and 6.
- R8: A counter write sets the value directly and overrides a same-cycle increment. An event counter keeps only the low 32 bits of the written data.
- R9: A 1 written to 0x41 or 0x42 sets or clears the matching enable bit, and a 0 leaves that bit alone. Both addresses read the enable register. Bits of counters that do not exist stay 0.
- R10: A 1 written to 0x43 or 0x44 sets or clears the matching overflow bit, and a 0 leaves that bit alone. A wrap in the same cycle as a clear leaves the flag set. Both addresses read the overflow register.
- R11: Type registers keep the low 10 bits of the written data. The type address of index 31 (0x3F) stores nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | NUM_EVT | One event pulse per event counter |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 7 | Register write address |
| wrData | input | 64 | Register write data |
| rdAddr | input | 7 | Register read address |
| rdData | output | 64 | Combinational read data |

## Verification
The hardest states to reach are the wrap points: the 64-bit carry through a chained pair, and the cycle counter crossing its 32-bit and 64-bit boundaries in both overflow modes. Counting up to these points is far too slow. The stimulus preloads each counter a step or two below all-ones through its write address. For the cycle counter it then opens global enable for an exact two-clock window, by following one control write directly with another. Same-cycle collisions are also driven on purpose: a write racing an event pulse, and an overflow clear racing a wrap.

// File: rtl/evtBankPkg.sv
`timescale 1ns/1ps
package evtBankPkg;
  localparam int CNT_W   = 32;
  localparam int CYC_W   = 64;
  localparam int TYPE_W  = 10;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 64;
  localparam int MASK_W  = 32;
  localparam int PAIR_W  = MASK_W / 2;
  localparam int CYC_IDX = 31;

  localparam logic [ADDR_W-1:0] ADDR_CYC    = 7'h1F;
  localparam logic [ADDR_W-1:0] ADDR_TYPE   = 7'h20;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 7'h40;
  localparam logic [ADDR_W-1:0] ADDR_ENSET  = 7'h41;
  localparam logic [ADDR_W-1:0] ADDR_ENCLR  = 7'h42;
  localparam logic [ADDR_W-1:0] ADDR_OVFSET = 7'h43;
  localparam logic [ADDR_W-1:0] ADDR_OVFCLR = 7'h44;
  localparam logic [ADDR_W-1:0] ADDR_SWINC  = 7'h45;

  localparam int CTL_EN  = 0;
  localparam int CTL_PCLR = 1;
  localparam int CTL_CCLR = 2;
  localparam int CTL_LONG = 6;

  localparam logic [TYPE_W-1:0] TYPE_SWINC = 10'h000;
  localparam logic [TYPE_W-1:0] TYPE_CHAIN = 10'h01E;

  typedef struct packed {
    logic [MASK_W-1:0] cntWr;
    logic              cycWr;
    logic [DATA_W-1:0] wrData;
    logic              clrEvt;
    logic              clrCyc;
    logic [MASK_W-1:0] ovfSet;
    logic [MASK_W-1:0] ovfClr;
    logic [MASK_W-1:0] incVec;
    logic              cycInc;
    logic              longCyc;
    logic [PAIR_W-1:0] pairChain;
  } strobe_t;
endpackage

// File: rtl/evtBankCtrl.sv
`timescale 1ns/1ps
module evtBankCtrl
  import evtBankPkg::*;
#(
  parameter int NUM_EVT = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_EVT-1:0]    evtPulse,
  output strobe_t               strb,
  output logic [MASK_W-1:0]     enReg,
  output logic                  globalEn,
  output logic                  longCyc,
  output logic [TYPE_W-1:0]     evtType [NUM_EVT]
);
  localparam logic [MASK_W-1:0] VALID =
    ((MASK_W'(1) << NUM_EVT) - MASK_W'(1)) | (MASK_W'(1) << CYC_IDX);
  localparam int NUM_PAIR = NUM_EVT / 2;

  logic hitCtrl, hitEnSet, hitEnClr, hitSwinc;
  assign hitCtrl  = wrEn && (wrAddr == ADDR_CTRL);
  assign hitEnSet = wrEn && (wrAddr == ADDR_ENSET);
  assign hitEnClr = wrEn && (wrAddr == ADDR_ENCLR);
  assign hitSwinc = wrEn && (wrAddr == ADDR_SWINC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      longCyc  <= 1'b0;
      enReg    <= '0;
    end else begin
      if (hitCtrl) begin
        globalEn <= wrData[CTL_EN];
        longCyc  <= wrData[CTL_LONG];
      end
      if (hitEnSet) enReg <= enReg | (wrData[MASK_W-1:0] & VALID);
      else if (hitEnClr) enReg <= enReg & ~wrData[MASK_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : gType
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evtType[g] <= '0;
      else if (wrEn && (wrAddr == ADDR_TYPE + ADDR_W'(g))) evtType[g] <= wrData[TYPE_W-1:0];
    end
  end

  always_comb begin
    strb         = '0;
    strb.wrData  = wrData;
    strb.cycWr   = wrEn && (wrAddr == ADDR_CYC);
    strb.clrEvt  = hitCtrl && wrData[CTL_PCLR];
    strb.clrCyc  = hitCtrl && wrData[CTL_CCLR];
    strb.ovfSet  = (wrEn && wrAddr == ADDR_OVFSET) ? (wrData[MASK_W-1:0] & VALID) : '0;
    strb.ovfClr  = (wrEn && wrAddr == ADDR_OVFCLR) ? wrData[MASK_W-1:0] : '0;
    strb.cycInc  = globalEn && enReg[CYC_IDX];
    strb.longCyc = longCyc;
    for (int p = 0; p < NUM_PAIR; p++)
      strb.pairChain[p] = (evtType[2*p+1] == TYPE_CHAIN);
    for (int i = 0; i < NUM_EVT; i++) begin
      logic isSw, oddChained;
      isSw       = (evtType[i] == TYPE_SWINC);
      oddChained = (i % 2 == 1) && strb.pairChain[i/2];
      strb.cntWr[i]  = wrEn && (wrAddr == ADDR_W'(i));
      strb.incVec[i] = !oddChained &&
        ((globalEn && enReg[i] && evtPulse[i] && !isSw) ||
         (hitSwinc && wrData[i] && isSw && enReg[i]));
    end
  end

  // R9: enable set and clear act bitwise on the written ones only
  p_en_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    hitEnSet |=> ((enReg & $past(wrData[MASK_W-1:0] & VALID)) == $past(wrData[MASK_W-1:0] & VALID)));
  p_en_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    hitEnClr |=> ((enReg & $past(wrData[MASK_W-1:0])) == '0));
  p_en_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enReg & ~VALID) == '0);
endmodule

// File: rtl/evtBankDatapath.sv
`timescale 1ns/1ps
module evtBankDatapath
  import evtBankPkg::*;
#(
  parameter int NUM_EVT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [CNT_W-1:0]  cnt [NUM_EVT],
  output logic [CYC_W-1:0]  cyc,
  output logic [MASK_W-1:0] ovf
);
  localparam logic [MASK_W-1:0] VALID =
    ((MASK_W'(1) << NUM_EVT) - MASK_W'(1)) | (MASK_W'(1) << CYC_IDX);
  localparam int NUM_PAIR = NUM_EVT / 2;
  localparam int LAST     = NUM_EVT - 1;

  logic [CNT_W-1:0]  nxtCnt [NUM_EVT];
  logic [CYC_W-1:0]  nxtCyc;
  logic [MASK_W-1:0] wrapHit;
  logic              unusedStrb;
  assign unusedStrb = ^{strb.pairChain, strb.incVec, strb.cntWr};

  always_comb begin
    wrapHit = '0;
    for (int i = 0; i < NUM_EVT; i++) nxtCnt[i] = cnt[i];
    for (int p = 0; p < NUM_PAIR; p++) begin
      if (strb.pairChain[p]) begin
        {nxtCnt[2*p+1], nxtCnt[2*p]} = {cnt[2*p+1], cnt[2*p]} + 64'(strb.incVec[2*p]);
        wrapHit[2*p+1] = strb.incVec[2*p] && (&cnt[2*p+1]) && (&cnt[2*p]);
      end else begin
        nxtCnt[2*p]     = cnt[2*p] + CNT_W'(strb.incVec[2*p]);
        wrapHit[2*p]    = strb.incVec[2*p] && (&cnt[2*p]);
        nxtCnt[2*p+1]   = cnt[2*p+1] + CNT_W'(strb.incVec[2*p+1]);
        wrapHit[2*p+1]  = strb.incVec[2*p+1] && (&cnt[2*p+1]);
      end
    end
    if (NUM_EVT % 2 == 1) begin
      nxtCnt[LAST]  = cnt[LAST] + CNT_W'(strb.incVec[LAST]);
      wrapHit[LAST] = strb.incVec[LAST] && (&cnt[LAST]);
    end
    for (int i = 0; i < NUM_EVT; i++) begin
      if (strb.clrEvt) begin
        nxtCnt[i]  = '0;
        wrapHit[i] = 1'b0;
      end
      if (strb.cntWr[i]) begin
        nxtCnt[i]  = strb.wrData[CNT_W-1:0];
        wrapHit[i] = 1'b0;
      end
    end
    nxtCyc = cyc + CYC_W'(strb.cycInc);
    wrapHit[CYC_IDX] = strb.cycInc && (strb.longCyc ? (&cyc) : (&cyc[CNT_W-1:0]));
    if (strb.clrCyc) begin
      nxtCyc = '0;
      wrapHit[CYC_IDX] = 1'b0;
    end
    if (strb.cycWr) begin
      nxtCyc = strb.wrData;
      wrapHit[CYC_IDX] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_EVT; i++) cnt[i] <= '0;
      cyc <= '0;
      ovf <= '0;
    end else begin
      for (int i = 0; i < NUM_EVT; i++) cnt[i] <= nxtCnt[i];
      cyc <= nxtCyc;
      ovf <= ((ovf & ~strb.ovfClr) | strb.ovfSet | wrapHit) & VALID;
    end
  end

  // R7: bulk clears take effect on the next edge
  p_pclr_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEvt && !strb.cntWr[0] |=> cnt[0] == '0);
  p_cclr_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCyc && !strb.cycWr |=> cyc == '0);
  // R3: an unchained counter at all-ones wraps to zero and flags overflow
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.incVec[0] && !strb.pairChain[0] && (&cnt[0]) && !strb.cntWr[0] && !strb.clrEvt
    |=> cnt[0] == '0 && ovf[0]);
  // R10: an overflow flag only falls after a clear write to it
  p_ovf_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (($past(ovf) & ~ovf & ~$past(strb.ovfClr)) == '0));
  // R6: the cycle counter holds when not enabled, written or cleared
  p_cyc_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cycInc && !strb.cycWr && !strb.clrCyc |=> $stable(cyc));
endmodule

// File: rtl/evtCounterBank.sv
`timescale 1ns/1ps
module evtCounterBank
  import evtBankPkg::*;
#(
  parameter int NUM_EVT = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               wrEn,
  input  logic [6:0]         wrAddr,
  input  logic [63:0]        wrData,
  input  logic [6:0]         rdAddr,
  output logic [63:0]        rdData
);
  strobe_t           strb;
  logic [MASK_W-1:0] enReg;
  logic [MASK_W-1:0] ovf;
  logic              globalEn, longCyc;
  logic [TYPE_W-1:0] evtType [NUM_EVT];
  logic [CNT_W-1:0]  cnt [NUM_EVT];
  logic [CYC_W-1:0]  cyc;

  evtBankCtrl #(.NUM_EVT(NUM_EVT)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtPulse(evtPulse), .strb(strb), .enReg(enReg), .globalEn(globalEn),
    .longCyc(longCyc), .evtType(evtType)
  );

  evtBankDatapath #(.NUM_EVT(NUM_EVT)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .cyc(cyc), .ovf(ovf)
  );

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (rdAddr == ADDR_W'(i)) rdData = {32'h0, cnt[i]};
      if (rdAddr == ADDR_TYPE + ADDR_W'(i)) rdData = DATA_W'(evtType[i]);
    end
    case (rdAddr)
      ADDR_CYC:                 rdData = cyc;
      ADDR_CTRL:                rdData = DATA_W'({longCyc, 5'b0, globalEn});
      ADDR_ENSET, ADDR_ENCLR:   rdData = DATA_W'(enReg);
      ADDR_OVFSET, ADDR_OVFCLR: rdData = DATA_W'(ovf);
      default: ;
    endcase
  end
endmodule

// File: tb/tb_evtCounterBank.sv
`timescale 1ns/1ps
module tb_evtCounterBank;
  localparam int NUM_EVT = 6;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_EVT-1:0] evtPulse = '0;
  logic               wrEn = 1'b0;
  logic [6:0]         wrAddr = '0;
  logic [63:0]        wrData = '0;
  logic [6:0]         rdAddr = '0;
  logic [63:0]        rdData;

  int checks = 0;
  int fails  = 0;

  evtCounterBank #(.NUM_EVT(NUM_EVT)) dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [6:0]  wa;
    logic [63:0] wd;
    logic [6:0]  ra;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{7'h00, 64'h0000_0001_2345_6789, 7'h00, 64'h2345_6789},           // R8
    '{7'h1F, 64'hDEAD_BEEF_0000_0001, 7'h1F, 64'hDEAD_BEEF_0000_0001}, // R6
    '{7'h22, 64'h0000_FFFF,           7'h22, 64'h3FF},                 // R11
    '{7'h3F, 64'h55,                  7'h3F, 64'h0},                   // R11
    '{7'h41, 64'h5,                   7'h41, 64'h5},                   // R9
    '{7'h41, 64'h2,                   7'h42, 64'h7},                   // R9
    '{7'h42, 64'h4,                   7'h41, 64'h3},                   // R9
    '{7'h42, 64'h0,                   7'h41, 64'h3},                   // R9
    '{7'h41, 64'h8010_0000,           7'h41, 64'h8000_0003},           // R9
    '{7'h43, 64'h9,                   7'h43, 64'h9},                   // R10
    '{7'h44, 64'h1,                   7'h44, 64'h8},                   // R10
    '{7'h40, 64'h46,                  7'h40, 64'h40},                  // R7
    '{7'h45, 64'h0,                   7'h1F, 64'h0},                   // R7
    '{7'h03, 64'h5,                   7'h03, 64'h5},                   // R8
    '{7'h40, 64'h02,                  7'h03, 64'h0},                   // R7
    '{7'h40, 64'h02,                  7'h00, 64'h0},                   // R7
    '{7'h40, 64'h00,                  7'h40, 64'h0}                    // R7
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rdChk(input logic [6:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    rdAddr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic wrPulse(input logic [6:0] a, input logic [63:0] d, input logic doWr,
                         input logic [NUM_EVT-1:0] pulses);
    @(negedge clk);
    wrEn = doWr; wrAddr = a; wrData = d; evtPulse = pulses;
    @(negedge clk);
    wrEn = 1'b0; evtPulse = '0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [63:0] d);
    wrPulse(a, d, 1'b1, '0);
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] m);
    wrPulse(7'h00, 64'h0, 1'b0, m);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; evtPulse = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Opens global enable for exactly two clock edges
  task automatic run2(input logic lc);
    wr(7'h40, {57'h0, lc, 6'h01});
    wr(7'h40, {57'h0, lc, 6'h00});
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    rdChk(7'h00, 64'h0, "R1 cnt0");
    rdChk(7'h1F, 64'h0, "R1 cyc");
    rdChk(7'h20, 64'h0, "R1 type0");
    rdChk(7'h40, 64'h0, "R1 ctrl");
    rdChk(7'h41, 64'h0, "R1 enable");
    rdChk(7'h43, 64'h0, "R1 overflow");

    for (int v = 0; v < NVEC; v++) begin
      wr(VECS[v].wa, VECS[v].wd);
      rdChk(VECS[v].ra, VECS[v].exp, $sformatf("table vector %0d", v));
    end

    // R2 gating by global and per-counter enable, SWINC type ignores pulses
    doReset();
    wr(7'h20, 64'h11);
    wr(7'h41, 64'h3);
    pulse(6'h1); pulse(6'h1); pulse(6'h1);
    rdChk(7'h00, 64'h0, "R2 no count without global enable");
    wr(7'h40, 64'h1);
    pulse(6'h3); pulse(6'h3);
    rdChk(7'h00, 64'h2, "R2 two pulses counted");
    rdChk(7'h01, 64'h0, "R2 SWINC type ignores pulses");
    wr(7'h42, 64'h1);
    pulse(6'h1);
    rdChk(7'h00, 64'h2, "R2 disabled counter holds");

    // R3 32-bit wrap
    wr(7'h41, 64'h1);
    wr(7'h00, 64'hFFFF_FFFE);
    pulse(6'h1);
    rdChk(7'h00, 64'hFFFF_FFFF, "R3 before wrap");
    rdChk(7'h43, 64'h0, "R3 no flag before wrap");
    pulse(6'h1);
    rdChk(7'h00, 64'h0, "R3 wrapped value");
    rdChk(7'h43, 64'h1, "R3 overflow flag");

    // R5 software increment
    doReset();
    wr(7'h20, 64'h11);
    wr(7'h41, 64'h8000_0003);
    wr(7'h01, 64'hFFFF_FFFF);
    wr(7'h45, 64'h8000_0007);
    rdChk(7'h00, 64'h0, "R5 non-SWINC type not incremented");
    rdChk(7'h01, 64'h0, "R5 increment wraps");
    rdChk(7'h02, 64'h0, "R5 disabled counter not incremented");
    rdChk(7'h1F, 64'h0, "R5 cycle counter untouched");
    rdChk(7'h43, 64'h2, "R5 wrap flag");
    wr(7'h45, 64'h2);
    rdChk(7'h01, 64'h1, "R5 increment without global enable");
    wr(7'h41, 64'h4);
    wr(7'h45, 64'h4);
    rdChk(7'h02, 64'h1, "R5 enabled counter incremented");

    // R4 chaining of pair 2/3
    doReset();
    wr(7'h22, 64'h11);
    wr(7'h23, 64'h1E);
    wr(7'h41, 64'h4);
    wr(7'h40, 64'h1);
    wr(7'h02, 64'hFFFF_FFFF);
    wr(7'h03, 64'h5);
    pulse(6'h04);
    rdChk(7'h02, 64'h0, "R4 low half");
    rdChk(7'h03, 64'h6, "R4 carry into high half");
    rdChk(7'h43, 64'h0, "R4 no flag on low wrap");
    pulse(6'h08);
    rdChk(7'h03, 64'h6, "R4 odd pulse ignored");
    wr(7'h03, 64'hFFFF_FFFF);
    wr(7'h02, 64'hFFFF_FFFF);
    pulse(6'h04);
    rdChk(7'h02, 64'h0, "R4 64-bit wrap low");
    rdChk(7'h03, 64'h0, "R4 64-bit wrap high");
    rdChk(7'h43, 64'h8, "R4 flag on odd only");

    // R6 cycle counter, both overflow modes
    doReset();
    wr(7'h41, 64'h8000_0000);
    wr(7'h1F, 64'hFFFF_FFFD);
    run2(1'b0);
    rdChk(7'h1F, 64'hFFFF_FFFF, "R6 two cycles counted");
    rdChk(7'h43, 64'h0, "R6 no flag yet");
    run2(1'b0);
    rdChk(7'h1F, 64'h1_0000_0001, "R6 counts past 32 bits");
    rdChk(7'h43, 64'h8000_0000, "R6 short mode flag");
    wr(7'h44, 64'h8000_0000);
    wr(7'h1F, 64'hFFFF_FFFF);
    run2(1'b1);
    rdChk(7'h1F, 64'h1_0000_0001, "R6 long mode value");
    rdChk(7'h43, 64'h0, "R6 long mode no flag at 32 bits");
    wr(7'h1F, 64'hFFFF_FFFF_FFFF_FFFE);
    run2(1'b1);
    rdChk(7'h1F, 64'h0, "R6 long mode 64-bit wrap");
    rdChk(7'h43, 64'h8000_0000, "R6 long mode flag");

    // R7 bulk clears
    doReset();
    wr(7'h00, 64'h7);
    wr(7'h02, 64'h9);
    wr(7'h1F, 64'h5);
    wr(7'h40, 64'h2);
    rdChk(7'h00, 64'h0, "R7 event clear cnt0");
    rdChk(7'h02, 64'h0, "R7 event clear cnt2");
    rdChk(7'h1F, 64'h5, "R7 event clear spares cycle");
    rdChk(7'h40, 64'h0, "R7 clear bits not stored");
    wr(7'h40, 64'h4);
    rdChk(7'h1F, 64'h0, "R7 cycle clear");

    // R8 write beats a same-cycle pulse
    doReset();
    wr(7'h20, 64'h11);
    wr(7'h41, 64'h1);
    wr(7'h40, 64'h1);
    wrPulse(7'h00, 64'd100, 1'b1, 6'h1);
    rdChk(7'h00, 64'd100, "R8 write overrides increment");
    pulse(6'h1);
    rdChk(7'h00, 64'd101, "R8 counts from written value");

    // R10 wrap beats a same-cycle clear; zero writes do nothing
    wr(7'h00, 64'hFFFF_FFFF);
    wrPulse(7'h44, 64'h1, 1'b1, 6'h1);
    rdChk(7'h43, 64'h1, "R10 wrap wins over clear");
    wr(7'h44, 64'h0);
    rdChk(7'h44, 64'h1, "R10 zero clear no effect");
    wr(7'h44, 64'h1);
    rdChk(7'h43, 64'h0, "R10 clear acknowledges");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule